// File: doc/BRIEF.md
# Two-Wide Issue Pairing Controller

This block sits at the issue point of an in-order pipeline that can start two instructions per cycle. Two pre-decoded slots are presented each cycle, an older one and a younger one. Each slot carries a class code and a few attribute flags. The controller decides whether both slots start together, only the older slot starts, or nothing starts. It also picks the execution lane for each instruction that starts. There are six lanes: two memory ports, two integer ALUs, one multiply-accumulate unit and one floating-point unit.

Pairing follows structural rules. The integer ALU is duplicated. The floating-point, multiply-accumulate and SIMD datapath counts as a single shared resource. Some instructions may only run alone. Two memory accesses pair only when both go to tightly coupled data memory, use different banks, and are at most 32 bits wide. A load that takes its address from a pointer register opens a short window in which nothing further starts.

The surrounding pipeline shifts the younger slot into the older position when only the older slot starts. The block itself is combinational, apart from the counter that times the pointer-load window.

Top module: `pair_issue_ctl`

## Requirements
- R1: After reset is released, no pointer-load window is pending. A valid older integer instruction whose lane is ready starts in the first cycle.
- R2: Lane select bit positions are fixed: bit 0 memory port 0, bit 1 memory port 1, bit 2 ALU 0, bit 3 ALU 1, bit 4 multiply-accumulate, bit 5 floating point. Class codes are 0 memory, 1 integer, 2 multiply-accumulate, 3 floating point. The older slot always uses memory port 0 or ALU 0 for its class. A slot that starts has exactly one lane bit set. A slot that does not start has none.
- R3: When both slots hold ordinary integer instructions, they start together: the older one on ALU 0 and the younger one on ALU 1. When only the younger slot is integer, it uses ALU 0.
- R4: At most one instruction that needs the shared resource starts per cycle. Such an instruction has class 2 or 3, or has its SIMD flag set.
- R5: An instruction with its single-issue flag set never starts together with another, whether it sits in the older or the younger slot.
- R6: Two memory instructions start together only when both target tightly coupled memory and their bank bits differ. Both size codes must also be at most MAX_PAIR_SIZE (size code 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits; default limit 2). The younger one then uses memory port 1.
- R7: A memory instruction whose target flag marks the cached system-memory path never starts together with another memory instruction.
- R8: An older pointer-address load starts alone. After any pointer-address load starts, the next GAP_CYCLES cycles start nothing.
- R9: The younger slot starts only in a cycle in which the older slot starts. An invalid older slot starts nothing.
- R10: If the lane chosen for the older slot is not ready, nothing starts. If only the younger slot's lane is not ready, the older slot starts alone.
- R11: The stall output is high exactly when the older slot is valid and does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| old_vld | input | 1 | Older slot holds an instruction |
| old_cls | input | 2 | Older slot class code |
| old_solo | input | 1 | Older slot must start alone |
| old_simd | input | 1 | Older slot needs the shared SIMD datapath |
| old_tcm | input | 1 | Older memory access targets tightly coupled memory (0 = cached path) |
| old_size | input | SIZE_W | Older access size code |
| old_bank | input | 1 | Older data-memory bank |
| old_ptrld | input | 1 | Older slot is a pointer-address load |
| yng_vld | input | 1 | Younger slot holds an instruction |
| yng_cls | input | 2 | Younger slot class code |
| yng_solo | input | 1 | Younger slot must start alone |
| yng_simd | input | 1 | Younger slot needs the shared SIMD datapath |
| yng_tcm | input | 1 | Younger memory access targets tightly coupled memory |
| yng_size | input | SIZE_W | Younger access size code |
| yng_bank | input | 1 | Younger data-memory bank |
| yng_ptrld | input | 1 | Younger slot is a pointer-address load |
| lane_rdy | input | 6 | Per-lane ready, bit order as in R2 |
| old_issue | output | 1 | Older slot starts this cycle |
| yng_issue | output | 1 | Younger slot starts this cycle |
| old_lane | output | 6 | One-hot lane of the older slot |
| yng_lane | output | 6 | One-hot lane of the younger slot |
| stall | output | 1 | Older slot is held |

## Verification
The bench sweeps every class and SIMD combination across the two slots. It also covers every memory target, bank and size combination, and every single-lane-not-ready case. Random traffic is mixed in, all against an arithmetic reference of the rules.

Each case targets a specific mistake:
- A controller that counted the shared resource per class instead of per instruction would pair a SIMD integer op with a multiply-accumulate op.
- One that only compared banks would pair 64-bit accesses.
- One that ignored the target flag would pair cached accesses.
- A pointer-load window that is one cycle short or long shows up as a wrong start in the cycles after the load.
- Sending the younger slot to the second lane without the older one holding the first would put two instructions on one lane, or leave the first lane idle.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

   localparam int CLS_W  = 2;
   localparam int NLANES = 6;

   typedef enum logic [CLS_W-1:0] {
      CLS_MEM = 2'd0,
      CLS_INT = 2'd1,
      CLS_MAC = 2'd2,
      CLS_FP  = 2'd3
   } iclass_e;

   localparam int LN_MEM0 = 0;
   localparam int LN_MEM1 = 1;
   localparam int LN_INT0 = 2;
   localparam int LN_INT1 = 3;
   localparam int LN_MAC  = 4;
   localparam int LN_FP   = 5;

   function automatic logic needs_shared(input logic [CLS_W-1:0] cls, input logic simd);
      return (cls == CLS_MAC) || (cls == CLS_FP) || simd;
   endfunction

endpackage

// File: rtl/pi_slot_decode.sv
module pi_slot_decode
   import pair_issue_pkg::*;
#(
   parameter bit IS_YOUNGER = 1'b0
) (
   input  logic [CLS_W-1:0]  cls,
   input  logic              simd,
   input  logic [CLS_W-1:0]  peer_cls,
   output logic [NLANES-1:0] lane_req,
   output logic              uses_shared,
   output logic              is_mem
);

   logic second;

   // the younger slot takes the second copy of a duplicated lane only when
   // the older slot already claims the first copy of that same lane kind
   generate
      if (IS_YOUNGER) begin : g_yng
         assign second = (peer_cls == cls);
      end else begin : g_old
         logic unused_peer;
         assign unused_peer = ^peer_cls;
         assign second      = 1'b0;
      end
   endgenerate

   always_comb begin
      lane_req = '0;
      unique case (iclass_e'(cls))
         CLS_MEM: lane_req[second ? LN_MEM1 : LN_MEM0] = 1'b1;
         CLS_INT: lane_req[second ? LN_INT1 : LN_INT0] = 1'b1;
         CLS_MAC: lane_req[LN_MAC] = 1'b1;
         CLS_FP:  lane_req[LN_FP]  = 1'b1;
         default: lane_req = '0;
      endcase
   end

   assign uses_shared = needs_shared(cls, simd);
   assign is_mem      = (iclass_e'(cls) == CLS_MEM);

endmodule

// File: rtl/pi_pair_rules.sv
module pi_pair_rules #(
   parameter int SIZE_W        = 2,
   parameter int MAX_PAIR_SIZE = 2
) (
   input  logic              o_solo,
   input  logic              y_solo,
   input  logic              o_ptrld,
   input  logic              o_shared,
   input  logic              y_shared,
   input  logic              o_mem,
   input  logic              y_mem,
   input  logic              o_tcm,
   input  logic              y_tcm,
   input  logic              o_bank,
   input  logic              y_bank,
   input  logic [SIZE_W-1:0] o_size,
   input  logic [SIZE_W-1:0] y_size,
   output logic              pair_ok
);

   localparam logic [SIZE_W-1:0] SZ_LIM = SIZE_W'(MAX_PAIR_SIZE);

   logic solo_block;
   logic shared_block;
   logic mem_block;
   logic both_mem;
   logic split_ok;
   logic narrow_ok;

   assign solo_block   = o_solo | y_solo | o_ptrld;
   assign shared_block = o_shared & y_shared;
   assign both_mem     = o_mem & y_mem;
   assign narrow_ok    = (o_size <= SZ_LIM) && (y_size <= SZ_LIM);
   assign split_ok     = o_tcm & y_tcm & (o_bank ^ y_bank) & narrow_ok;
   assign mem_block    = both_mem & ~split_ok;

   assign pair_ok = ~solo_block & ~shared_block & ~mem_block;

endmodule

// File: rtl/pi_gap_timer.sv
module pi_gap_timer #(
   parameter int GAP_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int GW = (GAP_CYCLES < 1) ? 1 : $clog2(GAP_CYCLES + 1);

   generate
      if (GAP_CYCLES == 0) begin : g_none
         logic unused_in;
         assign unused_in = start ^ clk ^ rst_n;
         assign busy      = 1'b0;
      end else begin : g_cnt
         logic [GW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (start)        cnt_q <= GW'(GAP_CYCLES);
            else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         end
         assign busy = (cnt_q != '0);
      end
   endgenerate

endmodule

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl
   import pair_issue_pkg::*;
#(
   parameter int SIZE_W        = 2,
   parameter int MAX_PAIR_SIZE = 2,
   parameter int GAP_CYCLES    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              old_vld,
   input  logic [1:0]        old_cls,
   input  logic              old_solo,
   input  logic              old_simd,
   input  logic              old_tcm,
   input  logic [SIZE_W-1:0] old_size,
   input  logic              old_bank,
   input  logic              old_ptrld,
   input  logic              yng_vld,
   input  logic [1:0]        yng_cls,
   input  logic              yng_solo,
   input  logic              yng_simd,
   input  logic              yng_tcm,
   input  logic [SIZE_W-1:0] yng_size,
   input  logic              yng_bank,
   input  logic              yng_ptrld,
   input  logic [5:0]        lane_rdy,
   output logic              old_issue,
   output logic              yng_issue,
   output logic [5:0]        old_lane,
   output logic [5:0]        yng_lane,
   output logic              stall
);

   generate
      if (SIZE_W < 1 || SIZE_W > 4) begin : g_bad_size_w
         $error("pair_issue_ctl: SIZE_W out of range");
      end
      if (MAX_PAIR_SIZE < 0 || MAX_PAIR_SIZE >= (1 << SIZE_W)) begin : g_bad_max
         $error("pair_issue_ctl: MAX_PAIR_SIZE must fit in SIZE_W");
      end
      if (GAP_CYCLES < 0 || GAP_CYCLES > 255) begin : g_bad_gap
         $error("pair_issue_ctl: GAP_CYCLES out of range");
      end
      if (NLANES != 6 || CLS_W != 2) begin : g_bad_pkg
         $error("pair_issue_ctl: port widths assume six lanes and 2-bit classes");
      end
   endgenerate

   logic [CLS_W-1:0]  cls_a   [2];
   logic              simd_a  [2];
   logic [CLS_W-1:0]  peer_a  [2];
   logic [NLANES-1:0] req_a   [2];
   logic              shr_a   [2];
   logic              mem_a   [2];

   assign cls_a[0]  = old_cls;
   assign cls_a[1]  = yng_cls;
   assign simd_a[0] = old_simd;
   assign simd_a[1] = yng_simd;
   assign peer_a[0] = yng_cls;
   assign peer_a[1] = old_cls;

   for (genvar s = 0; s < 2; s++) begin : g_slot
      pi_slot_decode #(.IS_YOUNGER(s == 1)) u_dec (
         .cls         (cls_a[s]),
         .simd        (simd_a[s]),
         .peer_cls    (peer_a[s]),
         .lane_req    (req_a[s]),
         .uses_shared (shr_a[s]),
         .is_mem      (mem_a[s])
      );
   end

   logic pair_ok;

   pi_pair_rules #(
      .SIZE_W        (SIZE_W),
      .MAX_PAIR_SIZE (MAX_PAIR_SIZE)
   ) u_rules (
      .o_solo   (old_solo),
      .y_solo   (yng_solo),
      .o_ptrld  (old_ptrld),
      .o_shared (shr_a[0]),
      .y_shared (shr_a[1]),
      .o_mem    (mem_a[0]),
      .y_mem    (mem_a[1]),
      .o_tcm    (old_tcm),
      .y_tcm    (yng_tcm),
      .o_bank   (old_bank),
      .y_bank   (yng_bank),
      .o_size   (old_size),
      .y_size   (yng_size),
      .pair_ok  (pair_ok)
   );

   logic gap_busy;
   logic gap_start;

   pi_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .start (gap_start),
      .busy  (gap_busy)
   );

   logic old_go;
   logic yng_go;

   assign old_go = old_vld & ~gap_busy & |(req_a[0] & lane_rdy);
   assign yng_go = old_go & yng_vld & pair_ok & |(req_a[1] & lane_rdy);

   assign old_issue = old_go;
   assign yng_issue = yng_go;
   assign old_lane  = old_go ? req_a[0] : '0;
   assign yng_lane  = yng_go ? req_a[1] : '0;
   assign stall     = old_vld & ~old_go;

   assign gap_start = (old_go & old_ptrld) | (yng_go & yng_ptrld);

endmodule

// File: rtl/pair_issue_ctl_chk.sv
module pair_issue_ctl_chk #(
   parameter int SIZE_W        = 2,
   parameter int MAX_PAIR_SIZE = 2,
   parameter int GAP_CYCLES    = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              old_vld,
   input logic [1:0]        old_cls,
   input logic              old_solo,
   input logic              old_simd,
   input logic              old_tcm,
   input logic [SIZE_W-1:0] old_size,
   input logic              old_bank,
   input logic              old_ptrld,
   input logic              yng_vld,
   input logic [1:0]        yng_cls,
   input logic              yng_solo,
   input logic              yng_simd,
   input logic              yng_tcm,
   input logic [SIZE_W-1:0] yng_size,
   input logic              yng_bank,
   input logic              yng_ptrld,
   input logic [5:0]        lane_rdy,
   input logic              old_issue,
   input logic              yng_issue,
   input logic [5:0]        old_lane,
   input logic [5:0]        yng_lane,
   input logic              stall
);

   localparam int GW = (GAP_CYCLES < 1) ? 1 : $clog2(GAP_CYCLES + 1);

   logic o_shr, y_shr, both_mem;
   assign o_shr    = (old_cls == 2'd2) || (old_cls == 2'd3) || old_simd;
   assign y_shr    = (yng_cls == 2'd2) || (yng_cls == 2'd3) || yng_simd;
   assign both_mem = (old_cls == 2'd0) && (yng_cls == 2'd0);

   logic [GW-1:0] quiet_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) quiet_q <= '0;
      else if ((old_issue && old_ptrld) || (yng_issue && yng_ptrld)) quiet_q <= GW'(GAP_CYCLES);
      else if (quiet_q != '0) quiet_q <= quiet_q - 1'b1;
   end

   assert_lane_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      old_issue |-> ($countones(old_lane) == 1) && $onehot0(yng_lane));

   assert_no_lane_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !yng_issue |-> (yng_lane == 6'd0));

   assert_no_lane_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
      yng_issue |-> ((old_lane & yng_lane) == 6'd0));

   assert_one_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      yng_issue |-> !(o_shr && y_shr));

   assert_solo_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
      yng_issue |-> !(old_solo || yng_solo));

   assert_mem_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (yng_issue && both_mem) |-> (old_bank != yng_bank)
         && (old_size <= SIZE_W'(MAX_PAIR_SIZE)) && (yng_size <= SIZE_W'(MAX_PAIR_SIZE)));

   assert_cache_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (yng_issue && both_mem) |-> (old_tcm && yng_tcm));

   assert_ptr_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_q != '0) |-> !old_issue);

   assert_ptr_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (old_issue && old_ptrld) |-> !yng_issue);

   assert_in_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      yng_issue |-> old_issue);

   assert_ready_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
      old_issue |-> ((old_lane & lane_rdy) != 6'd0));

   assert_stall_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (old_vld && !old_issue));

endmodule

bind pair_issue_ctl pair_issue_ctl_chk #(
   .SIZE_W        (SIZE_W),
   .MAX_PAIR_SIZE (MAX_PAIR_SIZE),
   .GAP_CYCLES    (GAP_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .old_vld   (old_vld),
   .old_cls   (old_cls),
   .old_solo  (old_solo),
   .old_simd  (old_simd),
   .old_tcm   (old_tcm),
   .old_size  (old_size),
   .old_bank  (old_bank),
   .old_ptrld (old_ptrld),
   .yng_vld   (yng_vld),
   .yng_cls   (yng_cls),
   .yng_solo  (yng_solo),
   .yng_simd  (yng_simd),
   .yng_tcm   (yng_tcm),
   .yng_size  (yng_size),
   .yng_bank  (yng_bank),
   .yng_ptrld (yng_ptrld),
   .lane_rdy  (lane_rdy),
   .old_issue (old_issue),
   .yng_issue (yng_issue),
   .old_lane  (old_lane),
   .yng_lane  (yng_lane),
   .stall     (stall)
);

// File: tb/pair_issue_ctl_test.sv
`timescale 1ns/1ps
module pair_issue_ctl_test;

   localparam int SW  = 2;
   localparam int MPS = 2;
   localparam int GAP = 2;

   localparam logic [5:0] L_M0 = 6'b000001;
   localparam logic [5:0] L_M1 = 6'b000010;
   localparam logic [5:0] L_I0 = 6'b000100;
   localparam logic [5:0] L_I1 = 6'b001000;
   localparam logic [5:0] L_MA = 6'b010000;
   localparam logic [5:0] L_FP = 6'b100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic o_vld, o_solo, o_simd, o_tcm, o_bank, o_ptr;
   logic y_vld, y_solo, y_simd, y_tcm, y_bank, y_ptr;
   logic [1:0] o_cls, y_cls;
   logic [SW-1:0] o_size, y_size;
   logic [5:0] rdy;
   logic iss_o, iss_y, stl;
   logic [5:0] ln_o, ln_y;

   int checks = 0;
   int fails  = 0;
   int mgap   = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pair_issue_ctl #(.SIZE_W(SW), .MAX_PAIR_SIZE(MPS), .GAP_CYCLES(GAP)) uut (
      .clk(clk), .rst_n(rst_n),
      .old_vld(o_vld), .old_cls(o_cls), .old_solo(o_solo), .old_simd(o_simd),
      .old_tcm(o_tcm), .old_size(o_size), .old_bank(o_bank), .old_ptrld(o_ptr),
      .yng_vld(y_vld), .yng_cls(y_cls), .yng_solo(y_solo), .yng_simd(y_simd),
      .yng_tcm(y_tcm), .yng_size(y_size), .yng_bank(y_bank), .yng_ptrld(y_ptr),
      .lane_rdy(rdy),
      .old_issue(iss_o), .yng_issue(iss_y), .old_lane(ln_o), .yng_lane(ln_y),
      .stall(stl)
   );

   function automatic logic [5:0] lane_of(input logic [1:0] c, input logic [1:0] peer, input bit yng);
      case (c)
         2'd0: return (yng && peer == 2'd0) ? L_M1 : L_M0;
         2'd1: return (yng && peer == 2'd1) ? L_I1 : L_I0;
         2'd2: return L_MA;
         default: return L_FP;
      endcase
   endfunction

   // reference of the pairing rules; result {old_issue, yng_issue, stall, old_lane, yng_lane}
   task automatic ref_model(output logic [14:0] exp, output string tag);
      logic [5:0] lo, ly;
      logic io, iy, osh, ysh;
      lo  = lane_of(o_cls, y_cls, 1'b0);
      ly  = lane_of(y_cls, o_cls, 1'b1);
      osh = (o_cls >= 2'd2) || o_simd;
      ysh = (y_cls >= 2'd2) || y_simd;
      io = 1'b0; iy = 1'b0;
      if (mgap != 0)                tag = "R8";
      else if (!o_vld)              tag = "R9";
      else if ((lo & rdy) == 6'd0)  tag = "R10";
      else begin
         io = 1'b1;
         if (!y_vld)                   tag = "R9";
         else if (o_solo || y_solo)    tag = "R5";
         else if (o_ptr)               tag = "R8";
         else if (osh && ysh)          tag = "R4";
         else if (o_cls == 2'd0 && y_cls == 2'd0 && !(o_tcm && y_tcm)) tag = "R7";
         else if (o_cls == 2'd0 && y_cls == 2'd0 &&
                  (o_bank == y_bank || o_size > MPS || y_size > MPS)) tag = "R6";
         else if ((ly & rdy) == 6'd0)  tag = "R10";
         else begin
            iy  = 1'b1;
            tag = (o_cls == 2'd1 && y_cls == 2'd1) ? "R3" : "R2";
         end
      end
      exp = {io, iy, o_vld && !io, io ? lo : 6'd0, iy ? ly : 6'd0};
   endtask

   task automatic clear_slots();
      o_vld = 0; o_cls = 0; o_solo = 0; o_simd = 0; o_tcm = 1; o_size = 0; o_bank = 0; o_ptr = 0;
      y_vld = 0; y_cls = 0; y_solo = 0; y_simd = 0; y_tcm = 1; y_size = 0; y_bank = 1; y_ptr = 0;
      rdy = 6'h3f;
   endtask

   // inputs are already set after a falling edge; sample before the next rising edge
   task automatic run_case(input string force_tag);
      logic [14:0] exp, act;
      string tag;
      #1;
      ref_model(exp, tag);
      if (force_tag != "") tag = force_tag;
      act = {iss_o, iss_y, stl, ln_o, ln_y};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h (o_cls=%0d y_cls=%0d rdy=%b gap=%0d)",
                  tag, act, exp, o_cls, y_cls, rdy, mgap);
      end
      if ((exp[14] && o_ptr) || (exp[13] && y_ptr)) mgap = GAP;
      else if (mgap != 0) mgap--;
      @(negedge clk);
   endtask

   initial begin
      #400000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      clear_slots();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: first cycle after reset, integer op on ALU 0 starts
      o_vld = 1; o_cls = 2'd1;
      run_case("R1");

      // R2 / R3 / R4: every class and SIMD combination across both slots
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int s = 0; s < 4; s++) begin
               clear_slots();
               o_vld = 1; y_vld = 1; o_cls = 2'(a); y_cls = 2'(b);
               o_simd = s[0]; y_simd = s[1];
               run_case("");
            end

      // R5: single-issue flag on each class, in each slot
      for (int a = 0; a < 4; a++) begin
         clear_slots();
         o_vld = 1; y_vld = 1; o_cls = 2'(a); y_cls = 2'd1; o_solo = 1;
         run_case("R5");
         clear_slots();
         o_vld = 1; y_vld = 1; o_cls = 2'd1; y_cls = 2'(a); y_solo = 1;
         run_case("R5");
      end

      // R6 / R7: every target, bank and size combination of two memory ops
      for (int m = 0; m < 256; m++) begin
         clear_slots();
         o_vld = 1; y_vld = 1; o_cls = 2'd0; y_cls = 2'd0;
         o_tcm = m[0]; y_tcm = m[1]; o_bank = m[2]; y_bank = m[3];
         o_size = SW'(m[5:4]); y_size = SW'(m[7:6]);
         run_case("");
      end

      // R10: each lane not ready in turn, over every class pair
      for (int l = 0; l < 6; l++)
         for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
               clear_slots();
               o_vld = 1; y_vld = 1; o_cls = 2'(a); y_cls = 2'(b);
               rdy = ~(6'd1 << l);
               run_case("R10");
            end

      // R8: older pointer load starts alone, then GAP quiet cycles, then issue resumes
      clear_slots();
      o_vld = 1; y_vld = 1; o_cls = 2'd0; y_cls = 2'd1; o_ptr = 1;
      run_case("R8");
      clear_slots();
      o_vld = 1; y_vld = 1; o_cls = 2'd1; y_cls = 2'd1;
      for (int k = 0; k < GAP + 1; k++) run_case("R8");

      // R8: younger pointer load paired with integer op also opens the window
      clear_slots();
      o_vld = 1; y_vld = 1; o_cls = 2'd1; y_cls = 2'd0; y_ptr = 1;
      run_case("R8");
      clear_slots();
      o_vld = 1; o_cls = 2'd1;
      for (int k = 0; k < GAP + 1; k++) run_case("R11");

      // R9: invalid older slot with valid younger starts nothing, no stall
      clear_slots();
      y_vld = 1; y_cls = 2'd1;
      run_case("R9");

      // random traffic against the reference
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r, q;
         r = $urandom;
         q = $urandom;
         o_vld  = (r[2:0] != 3'd0);   y_vld  = (r[5:3] != 3'd0);
         o_cls  = r[7:6];             y_cls  = r[9:8];
         o_solo = (r[12:10] == 3'd0); y_solo = (r[15:13] == 3'd0);
         o_simd = (r[17:16] == 2'd0); y_simd = (r[19:18] == 2'd0);
         o_tcm  = (r[21:20] != 2'd0); y_tcm  = (r[23:22] != 2'd0);
         o_size = SW'(r[25:24]);      y_size = SW'(r[27:26]);
         o_bank = r[28];              y_bank = r[29];
         o_ptr  = (q[3:0] == 4'd0);   y_ptr  = (q[7:4] == 4'd0);
         for (int l = 0; l < 6; l++) rdy[l] = (q[8 + 3*l +: 3] != 3'd0);
         run_case("");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule